// File: doc/BRIEF.md
# Lock-in Self-Centering Position Reference Controller

This block sits beside the force-rebalance loop of a capacitive proof-mass sensor. It generates a small sinusoidal excitation code. That code is added outside the block to a much larger DC tuning code on the differential tuning electrodes, so its amplitude is normally set about a hundred times below the DC level. The block then takes the digitized displacement samples and recovers the in-phase response to that excitation. It does this by demodulating twice: once against the readout carrier polarity and once against the excitation's own phase. Each demodulation is followed by a first-order shift-based low-pass stage.

The filtered in-phase response changes sign as the mass crosses the electrode gap center. A slow, saturating integrator therefore moves the position setpoint of the force-rebalance loop until that response is null, which parks the mass at the geometric center. The integrator acts only on the setpoint and never on the tuning voltage. Its gain is a right shift, which keeps the loop far slower than the rebalance loop. The excitation frequency word is chosen by the user above the rebalance bandwidth and apart from any other excitation on the tuning electrodes.

Top module: `lockin_center_ctrl`

## Requirements
- R1: While `rst` is high at a clock edge, `pos_ref`, `exc_code`, the phase accumulator and both filter states become zero.
- R2: Each `sample_vld` cycle adds `freq_word` to a 24-bit phase accumulator, modulo 2^24, and the phase holds in all other cycles. One cycle after the phase changes, `exc_code` equals (s * `amp_scale`) >>> 15. Here x = phase bits 22..11 taken as an unsigned value, m = min(32767, (x*(4096-x)) >> 7), and s = -m when phase bit 23 is 1, otherwise s = m.
- R3: The magnitude of `exc_code` never exceeds `amp_scale`.
- R4: First demodulation: the sample is negated when `carrier_neg` is 1. On each strobe, stage one updates y1 += (d1 - y1) >>> `lpf_shift`, an arithmetic shift that rounds toward minus infinity.
- R5: Second demodulation: y1 is negated when bit 23 of the phase is 1, using the phase value held before that strobe's advance. Stage two then updates y2 with the same rule and shift, using y1 from before the strobe.
- R6: On a strobe with `loop_en` high, `pos_ref` becomes `pos_ref` - (y2 >>> `ki_shift`), using y2 from before the strobe.
- R7: That update is clamped to the range [`ref_min`, `ref_max`].
- R8: In any cycle with `loop_en` low, `pos_ref` takes `ref_preset` at the next edge, whether or not a strobe is present. Enabling therefore starts from the preset.
- R9: Without a strobe, `pos_ref`, the filters and the phase hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sample_vld | input | 1 | Sample strobe |
| disp_sample | input | 16 | Signed displacement sample |
| carrier_neg | input | 1 | Readout carrier polarity, 1 = negative half |
| loop_en | input | 1 | Centering loop enable |
| freq_word | input | 24 | Excitation phase increment per strobe |
| amp_scale | input | 16 | Excitation amplitude scale (unsigned) |
| lpf_shift | input | 4 | Low-pass shift for both stages |
| ki_shift | input | 4 | Integral gain as right shift |
| ref_preset | input | 16 | Signed setpoint used while disabled |
| ref_min | input | 16 | Signed lower setpoint limit |
| ref_max | input | 16 | Signed upper setpoint limit |
| exc_code | output | 17 | Signed excitation code |
| pos_ref | output | 16 | Signed position setpoint to the rebalance loop |

## Verification
The loop update and the loop disable can both fall in one cycle: a strobe that arrives in the same cycle that `loop_en` drops. The bench drives exactly that pairing after the integrator has moved away from the preset. It judges the result by `pos_ref`, which must show the preset and not an integrated value. Clamping and a fresh error sample also coincide at the rails, where a large constant input is driven with zero gain shift and the result must sit on the limit the model predicts.

// File: rtl/lockin_pkg.sv
package lockin_pkg;
    localparam int PHASE_W   = 24;
    localparam int SINE_W    = 16;
    localparam int SINE_FRAC = 12;
    localparam int SINE_SH   = 2*SINE_FRAC - 2 - (SINE_W - 1);
    localparam int PROD_W    = 2*SINE_FRAC + 1;

    typedef logic [PHASE_W-1:0]        phase_t;
    typedef logic signed [SINE_W-1:0]  sine_t;

    typedef struct packed {
        logic fire;
        logic run;
    } step_t;

    // Parabolic half-wave sine approximation, signed by the phase MSB.
    function automatic sine_t sine_approx(input phase_t ph);
        logic [SINE_FRAC-1:0] xf;
        logic [SINE_FRAC:0]   xc;
        logic [PROD_W-1:0]    prod;
        logic [PROD_W-1:0]    mag;
        logic [PROD_W-1:0]    top;
        sine_t                m;
        xf   = ph[PHASE_W-2 -: SINE_FRAC];
        xc   = (SINE_FRAC+1)'(1 << SINE_FRAC) - {1'b0, xf};
        prod = {1'b0, xf} * xc;
        mag  = prod >> SINE_SH;
        top  = PROD_W'((1 << (SINE_W-1)) - 1);
        if (mag > top) mag = top;
        m = SINE_W'(mag);
        return ph[PHASE_W-1] ? -m : m;
    endfunction
endpackage

// File: rtl/sc_nco.sv
module sc_nco
    import lockin_pkg::*;
#(
    parameter int AMP_W = 16
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    adv,
    input  logic [PHASE_W-1:0]      freq_word,
    input  logic [AMP_W-1:0]        amp_scale,
    output logic [PHASE_W-1:0]      phase_o,
    output logic signed [AMP_W:0]   exc_o
);
    localparam int EW = AMP_W + 1;
    localparam int MW = SINE_W + AMP_W + 1;

    phase_t               phase_q;
    logic signed [MW-1:0] prod;

    assign prod = sine_approx(phase_q) * $signed({1'b0, amp_scale});

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= '0;
            exc_o   <= '0;
        end else begin
            if (adv) phase_q <= phase_q + freq_word;
            exc_o <= EW'(prod >>> (AMP_W - 1));
        end
    end

    assign phase_o = phase_q;
endmodule

// File: rtl/sc_lpf.sv
module sc_lpf #(
    parameter int W    = 17,
    parameter int SH_W = 4
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                en,
    input  logic [SH_W-1:0]     shift,
    input  logic signed [W-1:0] x,
    output logic signed [W-1:0] y
);
    logic signed [W:0] diff;
    logic signed [W:0] step;
    logic signed [W:0] sum;

    always_comb begin
        diff = {x[W-1], x} - {y[W-1], y};
        step = diff >>> shift;
        sum  = {y[W-1], y} + step;
    end

    always_ff @(posedge clk) begin
        if (rst)     y <= '0;
        else if (en) y <= W'(sum);
    end
endmodule

// File: rtl/sc_integ.sv
module sc_integ
    import lockin_pkg::*;
#(
    parameter int ERR_W = 18,
    parameter int REF_W = 16,
    parameter int SH_W  = 4
) (
    input  logic                    clk,
    input  logic                    rst,
    input  step_t                   ctl,
    input  logic [SH_W-1:0]         ki_shift,
    input  logic signed [ERR_W-1:0] err,
    input  logic signed [REF_W-1:0] preset,
    input  logic signed [REF_W-1:0] lo,
    input  logic signed [REF_W-1:0] hi,
    output logic signed [REF_W-1:0] ref_o
);
    localparam int CW = ((ERR_W > REF_W) ? ERR_W : REF_W) + 2;

    logic signed [CW-1:0] nxt;
    logic signed [REF_W-1:0] clamped;

    always_comb begin
        nxt = CW'(ref_o) - (CW'(err) >>> ki_shift);
        if (nxt > CW'(hi))      clamped = hi;
        else if (nxt < CW'(lo)) clamped = lo;
        else                    clamped = REF_W'(nxt);
    end

    always_ff @(posedge clk) begin
        if (rst)           ref_o <= '0;
        else if (!ctl.run) ref_o <= preset;
        else if (ctl.fire) ref_o <= clamped;
    end
endmodule

// File: rtl/lockin_center_ctrl.sv
module lockin_center_ctrl
    import lockin_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int AMP_W  = 16,
    parameter int REF_W  = 16,
    parameter int SH_W   = 4
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     sample_vld,
    input  logic signed [DATA_W-1:0] disp_sample,
    input  logic                     carrier_neg,
    input  logic                     loop_en,
    input  logic [PHASE_W-1:0]       freq_word,
    input  logic [AMP_W-1:0]         amp_scale,
    input  logic [SH_W-1:0]          lpf_shift,
    input  logic [SH_W-1:0]          ki_shift,
    input  logic signed [REF_W-1:0]  ref_preset,
    input  logic signed [REF_W-1:0]  ref_min,
    input  logic signed [REF_W-1:0]  ref_max,
    output logic signed [AMP_W:0]    exc_code,
    output logic signed [REF_W-1:0]  pos_ref
);
    localparam int L1W = DATA_W + 1;
    localparam int L2W = DATA_W + 2;

    phase_t               phase;
    logic signed [L1W-1:0] sx, d1, y1;
    logic signed [L2W-1:0] y1x, d2, y2;
    step_t                ctl;

    sc_nco #(.AMP_W(AMP_W)) u_nco (
        .clk(clk), .rst(rst), .adv(sample_vld),
        .freq_word(freq_word), .amp_scale(amp_scale),
        .phase_o(phase), .exc_o(exc_code)
    );

    // carrier demodulation
    assign sx = {disp_sample[DATA_W-1], disp_sample};
    assign d1 = carrier_neg ? -sx : sx;

    sc_lpf #(.W(L1W), .SH_W(SH_W)) u_lpf_carrier (
        .clk(clk), .rst(rst), .en(sample_vld), .shift(lpf_shift),
        .x(d1), .y(y1)
    );

    // excitation-reference demodulation, in-phase only
    assign y1x = {y1[L1W-1], y1};
    assign d2  = phase[PHASE_W-1] ? -y1x : y1x;

    sc_lpf #(.W(L2W), .SH_W(SH_W)) u_lpf_exc (
        .clk(clk), .rst(rst), .en(sample_vld), .shift(lpf_shift),
        .x(d2), .y(y2)
    );

    assign ctl.fire = sample_vld;
    assign ctl.run  = loop_en;

    sc_integ #(.ERR_W(L2W), .REF_W(REF_W), .SH_W(SH_W)) u_integ (
        .clk(clk), .rst(rst), .ctl(ctl), .ki_shift(ki_shift), .err(y2),
        .preset(ref_preset), .lo(ref_min), .hi(ref_max), .ref_o(pos_ref)
    );
endmodule

// File: rtl/lockin_center_chk.sv
module lockin_center_chk #(
    parameter int AMP_W   = 16,
    parameter int REF_W   = 16,
    parameter int PHASE_W = 24
) (
    input logic                    clk,
    input logic                    rst,
    input logic                    sample_vld,
    input logic                    loop_en,
    input logic [AMP_W-1:0]        amp_scale,
    input logic signed [REF_W-1:0] ref_preset,
    input logic signed [REF_W-1:0] ref_min,
    input logic signed [REF_W-1:0] ref_max,
    input logic signed [AMP_W:0]   exc_code,
    input logic signed [REF_W-1:0] pos_ref,
    input logic [PHASE_W-1:0]      phase
);
    logic signed [AMP_W:0] exc_neg;
    logic [AMP_W:0]        exc_mag;
    assign exc_neg = -exc_code;
    assign exc_mag = exc_code[AMP_W] ? exc_neg : exc_code;

    assert_exc_bound_R3: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> exc_mag <= {1'b0, $past(amp_scale)});

    assert_ref_range_R7: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(loop_en) && $past(sample_vld))
        |-> (pos_ref >= $past(ref_min) && pos_ref <= $past(ref_max)));

    assert_preset_when_off_R8: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(loop_en)) |-> pos_ref == $past(ref_preset));

    assert_ref_hold_R9: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(sample_vld) && $past(loop_en)) |-> $stable(pos_ref));

    assert_phase_hold_R2: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(sample_vld)) |-> $stable(phase));
endmodule

bind lockin_center_ctrl lockin_center_chk #(
    .AMP_W(AMP_W), .REF_W(REF_W), .PHASE_W(lockin_pkg::PHASE_W)
) u_chk (
    .clk(clk), .rst(rst), .sample_vld(sample_vld), .loop_en(loop_en),
    .amp_scale(amp_scale), .ref_preset(ref_preset), .ref_min(ref_min),
    .ref_max(ref_max), .exc_code(exc_code), .pos_ref(pos_ref), .phase(phase)
);

// File: tb/test_lockin_center_ctrl.sv
module test_lockin_center_ctrl;
    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic               sample_vld = 1'b0;
    logic signed [15:0] disp_sample = '0;
    logic               carrier_neg = 1'b0;
    logic               loop_en = 1'b0;
    logic [23:0]        freq_word = '0;
    logic [15:0]        amp_scale = '0;
    logic [3:0]         lpf_shift = 4'd2;
    logic [3:0]         ki_shift = 4'd3;
    logic signed [15:0] ref_preset = 16'sd100;
    logic signed [15:0] ref_min = -16'sd2000;
    logic signed [15:0] ref_max = 16'sd2000;
    logic signed [16:0] exc_code;
    logic signed [15:0] pos_ref;

    int  n_checks = 0;
    int  n_errors = 0;
    bit  done = 0;

    longint m_y1, m_y2, m_ref, m_phase;

    always #10ns clk = ~clk;

    lockin_center_ctrl i_lockin_center_ctrl (
        .clk(clk), .rst(rst), .sample_vld(sample_vld), .disp_sample(disp_sample),
        .carrier_neg(carrier_neg), .loop_en(loop_en), .freq_word(freq_word),
        .amp_scale(amp_scale), .lpf_shift(lpf_shift), .ki_shift(ki_shift),
        .ref_preset(ref_preset), .ref_min(ref_min), .ref_max(ref_max),
        .exc_code(exc_code), .pos_ref(pos_ref)
    );

    task automatic chk(input string req, input longint act, input longint exp);
        n_checks++;
        if (act != exp) begin
            n_errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic longint m_sine(input longint ph);
        longint x, m;
        x = (ph >> 11) & 4095;
        m = (x * (4096 - x)) >> 7;
        if (m > 32767) m = 32767;
        return ((ph >> 23) & 1) ? -m : m;
    endfunction

    function automatic longint m_exc(input longint ph, input longint amp);
        return (m_sine(ph) * amp) >>> 15;
    endfunction

    task automatic model_reset();
        m_y1 = 0; m_y2 = 0; m_ref = 0; m_phase = 0;
    endtask

    // reference model step (R4, R5, R6, R7, R8, R2 phase)
    task automatic model_step(input bit vld, input longint x, input bit cneg);
        longint d1, d2, ny1, ny2, nr;
        if (vld) begin
            d1  = cneg ? -x : x;
            ny1 = m_y1 + ((d1 - m_y1) >>> lpf_shift);
            d2  = ((m_phase >> 23) & 1) ? -m_y1 : m_y1;
            ny2 = m_y2 + ((d2 - m_y2) >>> lpf_shift);
            nr  = m_ref - (m_y2 >>> ki_shift);
            if (nr > longint'(ref_max)) nr = ref_max;
            else if (nr < longint'(ref_min)) nr = ref_min;
            if (loop_en) m_ref = nr;
            m_y1 = ny1; m_y2 = ny2;
            m_phase = (m_phase + longint'(freq_word)) & 24'hFFFFFF;
        end
        if (!loop_en) m_ref = ref_preset;
    endtask

    task automatic tick(input bit vld, input longint x, input bit cneg);
        sample_vld  = vld;
        disp_sample = 16'(x);
        carrier_neg = cneg;
        @(posedge clk);
        model_step(vld, x, cneg);
        @(negedge clk);
    endtask

    task automatic do_reset();
        rst = 1'b1;
        sample_vld = 1'b0;
        @(posedge clk); @(posedge clk);
        @(negedge clk);
        model_reset();
        chk("R1 pos_ref in reset", pos_ref, 0);
        chk("R1 exc_code in reset", exc_code, 0);
        rst = 1'b0;
    endtask

    initial begin
        #(20ns * 150000);
        if (!done) begin
            n_checks++; n_errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4711));
        @(negedge clk);
        do_reset();

        // R8: disabled loop follows preset
        tick(0, 0, 0);
        chk("R8 preset while disabled", pos_ref, 100);

        // R9: enabled without strobe holds
        loop_en = 1'b1;
        for (int i = 0; i < 4; i++) begin
            tick(0, 0, 0);
            chk("R9 hold without strobe", pos_ref, 100);
        end

        // R4 R5 R6: random stimulus against the model
        for (int blk = 0; blk < 6; blk++) begin
            lpf_shift = 4'($urandom_range(0, 5));
            ki_shift  = 4'($urandom_range(2, 8));
            freq_word = 24'($urandom);
            for (int i = 0; i < 120; i++) begin
                tick($urandom_range(0, 9) < 7, longint'($signed($urandom)) >>> 16,
                     1'($urandom));
                chk("R6 integrated setpoint (R4 R5 chain)", pos_ref, m_ref);
            end
        end

        // R7: drive to the rails with zero gain shift
        ref_min = -16'sd50; ref_max = 16'sd60; ki_shift = 4'd0; freq_word = '0;
        for (int i = 0; i < 20; i++) begin
            tick(1, 20000, 0);
            chk("R7 clamped setpoint", pos_ref, m_ref);
        end
        chk("R7 on a rail", longint'(pos_ref == 60 || pos_ref == -50), 1);

        // R8: strobe coinciding with disable; preset wins
        ref_preset = 16'sd7;
        loop_en = 1'b0;
        tick(1, 20000, 0);
        chk("R8 disable beats strobe", pos_ref, 7);
        loop_en = 1'b1;
        tick(1, -20000, 1);
        chk("R8 restart from preset", pos_ref, m_ref);

        // R1 mid-run: filters cleared, zero input leaves preset untouched
        ref_min = -16'sd2000; ref_max = 16'sd2000; ki_shift = 4'd0;
        loop_en = 1'b0;
        do_reset();
        tick(0, 0, 0);
        loop_en = 1'b1;
        for (int i = 0; i < 3; i++) begin
            tick(1, 0, 0);
            chk("R1 filters cleared by reset", pos_ref, 7);
        end

        // R2: directed quadrants of the excitation
        do_reset();
        amp_scale = 16'd40000; freq_word = 24'h400000;
        tick(0, 0, 0);
        chk("R2 excitation at phase zero", exc_code, 0);
        for (int q = 1; q < 5; q++) begin
            tick(1, 0, 0);
            tick(0, 0, 0);
            chk("R2 excitation quadrant", exc_code, m_exc(m_phase, amp_scale));
        end

        // R2 R3: random phases and amplitudes
        for (int i = 0; i < 60; i++) begin
            amp_scale = 16'($urandom);
            freq_word = 24'($urandom);
            tick(1, 0, 0);
            tick(0, 0, 0);
            chk("R2 excitation value", exc_code, m_exc(m_phase, amp_scale));
            chk("R3 excitation bound",
                longint'((exc_code < 0 ? -longint'(exc_code) : longint'(exc_code))
                         <= longint'(amp_scale)), 1);
        end

        done = 1;
        $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
        $finish;
    end
endmodule